// File: doc/BRIEF.md
# Dual-Table Keyword Automaton Stepper

This block advances a deterministic multi-keyword matching automaton by one input character on each accepted transfer. The transitions live in two small constant lookup tables. The prefix-extension table holds the edges that grow the current matched prefix by one character. The branch-jump table holds the edges that move the automaton onto a different prefix after a mismatch. Both tables are searched in the same cycle with the pair (current state, character), and the result becomes the next state.

The compiled-in keyword set is "app" (keyword ID 0) and "past" (keyword ID 1). The state codes are: 0 = root (empty prefix), 1 = "a", 2 = "ap", 3 = "app", 4 = "p", 5 = "pa", 6 = "pas", 7 = "past".

The character input is a valid/ready stream. The block never applies back-pressure: `in_ready` is held high, so every cycle with `in_valid` high is a transfer. The state and match outputs are plain status pins with no handshake. A match strobe rises in the same cycle that `state_o` first shows the accepting state, and it lasts for exactly one cycle.

Top module: `kw_dfa_step`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `state_o` is 0 (root) and `match_valid_o` is 0.
- R2: `in_ready` is always 1, and every cycle with `in_valid` high consumes exactly one character. The new state appears on `state_o` one clock after the transfer.
- R3: In a cycle with `in_valid` low, `state_o` keeps its value whatever `in_char` carries, and `match_valid_o` is 0 in the following cycle.
- R4: Prefix-extension edges are 0-'a'->1, 1-'p'->2, 2-'p'->3, 0-'p'->4, 4-'a'->5, 5-'s'->6 and 6-'t'->7.
- R5: Branch-jump edges are 1-'a'->1, 2-'a'->5, 3-'a'->5, 3-'p'->4, 4-'p'->4, 5-'a'->1, 5-'p'->2, 6-'a'->1, 6-'p'->4, 7-'a'->1 and 7-'p'->4. For example, "app" followed by 'a' goes to "pa".
- R6: A (state, character) pair found in neither table sends the automaton to root (0).
- R7: When both tables hit, the prefix-extension edge wins. The branch-jump table also holds a stale entry 2-'p'->4, so "ap" followed by 'p' must go to 3, not 4.
- R8: A transfer that enters state 3 raises `match_valid_o` with `match_id_o` = 0. A transfer that enters state 7 raises it with `match_id_o` = 1. Both appear in the cycle that `state_o` first shows the accepting state.
- R9: `match_valid_o` is high for one cycle per match, even when the automaton stays in the accepting state because `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Character stream valid |
| in_ready | output | 1 | Character stream ready, held at 1 |
| in_char | input | 8 | Character byte |
| state_o | output | 3 | Current automaton state |
| match_valid_o | output | 1 | One-cycle strobe on entering an accepting state |
| match_id_o | output | 2 | Keyword ID of the match, meaningful with the strobe |

## Verification
The pair "ap" + 'p' hits both tables at once. On that same transfer the automaton enters an accepting state, so the priority choice and the match strobe are decided in one cycle. The bench provokes this inside ".appastxyz" and again after the jump "pa" + 'p'. A correct result requires `state_o` = 3 together with a strobe carrying ID 0; the stale target 4 with no strobe would be reported. A strobe followed immediately by an idle cycle also checks that the accepting state is held while the strobe drops.

// File: rtl/kw_dfa_pkg.sv
package kw_dfa_pkg;
  localparam int CHAR_W  = 8;
  localparam int STATE_W = 3;
  localparam int ID_W    = 2;
  localparam int EDGE_W  = 2 * STATE_W + CHAR_W;
  localparam int ACC_W   = STATE_W + ID_W;
  localparam int FWD_N   = 7;
  localparam int JMP_N   = 12;
  localparam int ACC_N   = 2;
  localparam logic [STATE_W-1:0] ROOT = '0;

  // Edge record layout: {source state, character, destination state}
  function automatic logic [EDGE_W-1:0] mk_edge(int s, logic [CHAR_W-1:0] c, int d);
    logic [STATE_W-1:0] ss;
    logic [STATE_W-1:0] dd;
    ss = s[STATE_W-1:0];
    dd = d[STATE_W-1:0];
    return {ss, c, dd};
  endfunction

  // Accepting record layout: {state, keyword id}
  function automatic logic [ACC_W-1:0] mk_acc(int s, int id);
    logic [STATE_W-1:0] ss;
    logic [ID_W-1:0]    ii;
    ss = s[STATE_W-1:0];
    ii = id[ID_W-1:0];
    return {ss, ii};
  endfunction

  // Entry 0 sits in the lowest bits; lower index wins inside one table.
  localparam logic [FWD_N*EDGE_W-1:0] FWD_TBL = {
    mk_edge(6, "t", 7), mk_edge(5, "s", 6), mk_edge(4, "a", 5),
    mk_edge(0, "p", 4), mk_edge(2, "p", 3), mk_edge(1, "p", 2),
    mk_edge(0, "a", 1)
  };

  localparam logic [JMP_N*EDGE_W-1:0] JMP_TBL = {
    mk_edge(2, "p", 4),  // stale entry, shadowed by the extension table
    mk_edge(7, "p", 4), mk_edge(7, "a", 1), mk_edge(6, "p", 4),
    mk_edge(6, "a", 1), mk_edge(5, "p", 2), mk_edge(5, "a", 1),
    mk_edge(4, "p", 4), mk_edge(3, "p", 4), mk_edge(3, "a", 5),
    mk_edge(2, "a", 5), mk_edge(1, "a", 1)
  };

  localparam logic [ACC_N*ACC_W-1:0] ACC_TBL = {
    mk_acc(7, 1), mk_acc(3, 0)
  };
endpackage

// File: rtl/kw_edge_lookup.sv
module kw_edge_lookup #(
  parameter int N  = 4,
  parameter int SW = 3,
  parameter int CW = 8,
  parameter logic [N*(2*SW+CW)-1:0] TBL = '0
) (
  input  logic [SW-1:0] cur,
  input  logic [CW-1:0] chr,
  output logic          hit,
  output logic [SW-1:0] dst
);
  localparam int EW = 2 * SW + CW;

  logic [N-1:0]  hv;
  logic [SW-1:0] dst_arr [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    localparam logic [EW-1:0] ENT = TBL[i*EW +: EW];
    localparam logic [SW-1:0] SRC = ENT[EW-1 -: SW];
    localparam logic [CW-1:0] CHR = ENT[SW+CW-1 -: CW];
    assign hv[i]      = (cur == SRC) && (chr == CHR);
    assign dst_arr[i] = ENT[SW-1:0];
  end

  // Lowest-index hit selects the destination.
  always_comb begin
    hit = 1'b0;
    dst = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hv[i]) begin
        hit = 1'b1;
        dst = dst_arr[i];
      end
    end
  end
endmodule

// File: rtl/kw_accept_map.sv
module kw_accept_map #(
  parameter int N  = 2,
  parameter int SW = 3,
  parameter int IW = 2,
  parameter logic [N*(SW+IW)-1:0] TBL = '0
) (
  input  logic [SW-1:0] st,
  output logic          acc,
  output logic [IW-1:0] id
);
  localparam int AW = SW + IW;

  logic [N-1:0]  hv;
  logic [IW-1:0] id_arr [N];

  for (genvar i = 0; i < N; i++) begin : g_acc
    localparam logic [AW-1:0] ENT = TBL[i*AW +: AW];
    assign hv[i]     = (st == ENT[AW-1 -: SW]);
    assign id_arr[i] = ENT[IW-1:0];
  end

  always_comb begin
    acc = 1'b0;
    id  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hv[i]) begin
        acc = 1'b1;
        id  = id_arr[i];
      end
    end
  end
endmodule

// File: rtl/kw_dfa_step.sv
module kw_dfa_step
  import kw_dfa_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [CHAR_W-1:0]  in_char,
  output logic [STATE_W-1:0] state_o,
  output logic               match_valid_o,
  output logic [ID_W-1:0]    match_id_o
);
  logic               fire;
  logic               f_hit, j_hit, nxt_acc;
  logic [STATE_W-1:0] f_dst, j_dst, nxt;
  logic [ID_W-1:0]    nxt_id;
  logic [STATE_W-1:0] st_q;
  logic               mv_q;
  logic [ID_W-1:0]    id_q;

  assign in_ready = 1'b1;
  assign fire     = in_valid && in_ready;

  kw_edge_lookup #(.N(FWD_N), .SW(STATE_W), .CW(CHAR_W), .TBL(FWD_TBL)) u_fwd (
    .cur(st_q), .chr(in_char), .hit(f_hit), .dst(f_dst)
  );

  kw_edge_lookup #(.N(JMP_N), .SW(STATE_W), .CW(CHAR_W), .TBL(JMP_TBL)) u_jmp (
    .cur(st_q), .chr(in_char), .hit(j_hit), .dst(j_dst)
  );

  // Extension edge first, then jump edge, else back to root.
  always_comb begin
    if (f_hit)      nxt = f_dst;
    else if (j_hit) nxt = j_dst;
    else            nxt = ROOT;
  end

  kw_accept_map #(.N(ACC_N), .SW(STATE_W), .IW(ID_W), .TBL(ACC_TBL)) u_acc (
    .st(nxt), .acc(nxt_acc), .id(nxt_id)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ROOT;
      mv_q <= 1'b0;
      id_q <= '0;
    end else if (fire) begin
      st_q <= nxt;
      mv_q <= nxt_acc;
      id_q <= nxt_id;
    end else begin
      mv_q <= 1'b0;
    end
  end

  assign state_o       = st_q;
  assign match_valid_o = mv_q;
  assign match_id_o    = id_q;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(state_o));
  p_miss_root_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !f_hit && !j_hit) |=> (state_o == ROOT));
  p_fwd_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && f_hit) |=> (state_o == $past(f_dst)));
  p_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !f_hit && j_hit) |=> (state_o == $past(j_dst)));
  p_strobe_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid_o |-> $past(in_valid));
  p_strobe_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_valid_o && !in_valid) |=> !match_valid_o);
  p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);
endmodule

// File: tb/sim_kw_dfa_step.sv
module sim_kw_dfa_step;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_char = 8'h00;
  logic [2:0] state_o;
  logic       match_valid_o;
  logic [1:0] match_id_o;

  int n_cmp = 0;
  int n_bad = 0;
  int m_state = 0;

  typedef struct {
    int    st;
    bit    mv;
    int    id;
    string tag;
  } exp_t;
  exp_t exq [$];

  string names [8] = '{"", "a", "ap", "app", "p", "pa", "pas", "past"};

  always #2.5 clk = ~clk;

  kw_dfa_step u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_char(in_char), .state_o(state_o), .match_valid_o(match_valid_o),
    .match_id_o(match_id_o)
  );

  // Reference: longest suffix of (prefix + char) that is itself a keyword prefix.
  function automatic int ref_next(int st, byte c);
    string s;
    s = $sformatf("%s%c", names[st], c);
    for (int len = s.len(); len > 0; len--) begin
      string suf;
      suf = s.substr(s.len() - len, s.len() - 1);
      for (int k = 1; k < 8; k++) if (names[k] == suf) return k;
    end
    return 0;
  endfunction

  task automatic send(byte c, bit v, string tag);
    exp_t e;
    @(negedge clk);
    in_valid = v;
    in_char  = c;
    if (v) begin
      m_state = ref_next(m_state, c);
      e.mv = (m_state == 3) || (m_state == 7);
    end else begin
      e.mv = 1'b0;
    end
    e.st  = m_state;
    e.id  = (m_state == 7) ? 1 : 0;
    e.tag = tag;
    exq.push_back(e);
  endtask

  task automatic send_str(string s, string tag);
    for (int i = 0; i < s.len(); i++) send(s[i], 1'b1, tag);
  endtask

  // Monitor: compares each result one clock after its transfer.
  always @(posedge clk) begin
    #2;
    if (exq.size() > 0) begin
      exp_t e;
      e = exq.pop_front();
      n_cmp++;
      if (state_o !== e.st[2:0] || match_valid_o !== e.mv ||
          (e.mv && match_id_o !== e.id[1:0]) || in_ready !== 1'b1) begin
        n_bad++;
        $display("FAIL %s/R2: state=%0d mv=%0b id=%0d rdy=%0b expected state=%0d mv=%0b id=%0d rdy=1",
                 e.tag, state_o, match_valid_o, match_id_o, in_ready, e.st, e.mv, e.id);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    string       alpha;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;  // R1: reset state during reset
    if (state_o !== 3'd0 || match_valid_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: state=%0d mv=%0b expected state=0 mv=0", state_o, match_valid_o);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_cmp++;  // R1: first cycle after reset
    if (state_o !== 3'd0 || match_valid_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: state=%0d mv=%0b expected state=0 mv=0", state_o, match_valid_o);
    end
    send(".", 1'b1, "R6");
    send_str("ap", "R4");
    send("p", 1'b1, "R7");      // both tables hit; also a match (R8)
    send("a", 1'b1, "R5");
    send_str("st", "R8");
    send("t", 1'b0, "R9");      // strobe must drop, state holds
    send("q", 1'b0, "R3");
    send_str("xyz", "R6");
    send_str("pa", "R4");
    send("p", 1'b1, "R5");
    send("p", 1'b1, "R8");
    send("p", 1'b1, "R5");
    send("a", 1'b0, "R3");      // char ignored while invalid
    send("p", 1'b1, "R5");
    send("q", 1'b1, "R6");
    send_str("pastp", "R5");
    send_str("aa", "R5");
    send_str("apa", "R5");
    send_str("appapp", "R8");
    lfsr  = 16'hACE1;
    alpha = "apstx";
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(alpha[lfsr % 5], lfsr[7] | lfsr[3], "R2");
    end
    @(negedge clk);
    in_valid = 1'b0;
    while (exq.size() > 0) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule